// File: doc/BRIEF.md
# Channel Timestamp Capture Unit

This block gives one output channel of a beam-synchronous trigger generator a free-running timestamp. A counter advances on a selectable clock: either the revolution-period tick or each arrival of one chosen event code on the decoded event stream. A second configured event code acts as a timestamp reset and returns the counter to zero. When a chosen trigger condition occurs, the current counter value is copied into a capture register. The trigger can be a matching event code, the first output pulse of a series, or the halt strobe that ends a series.

Each capture sets a sticky per-channel flag for the interrupt logic, which clears it with an acknowledge strobe. The captured value is also offered one byte at a time through a byte index, with the most significant byte at index 0.

Top module: `ts_capture_unit`

## Requirements
- R1: After a synchronous active-low reset, the counter, the captured value and the capture flag are all zero.
- R2: When an event is valid and its code equals the sync code, the counter reads zero after that clock edge. This clear takes priority over any increment in the same cycle.
- R3: With mode bit 3 at 0, the counter grows by exactly one for each cycle in which the revolution tick is high. Event codes other than the sync code do not change it.
- R4: With mode bit 3 at 1, the counter grows by exactly one for each valid event whose code equals the clock code. The revolution tick does not change it.
- R5: The counter wraps from all-ones to zero on an increment.
- R6: With mode bit 0 set, a valid event whose code equals the trigger code loads the captured value. The value loaded is the counter value held before that same edge.
- R7: With mode bit 1 set, a first-pulse strobe loads the captured value in the same way.
- R8: With mode bit 2 set, a halt strobe loads the captured value in the same way.
- R9: A condition whose mode bit is clear has no effect on the captured value or the flag.
- R10: Several enabled conditions in one cycle produce a single capture of the pre-edge counter value.
- R11: A capture sets the flag on the next edge. The flag stays set until a cycle in which the acknowledge input is high and no capture occurs.
- R12: The byte output is combinational. Index 0 gives the most significant byte of the captured value, and each higher index gives the next lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rev_tick | input | 1 | Revolution-period tick, one cycle wide |
| evt_valid | input | 1 | Decoded event code present this cycle |
| evt_code | input | CODE_W | Decoded event code |
| first_pulse | input | 1 | First output pulse of a series |
| halt_pulse | input | 1 | Halt strobe from the channel |
| sync_code | input | CODE_W | Event code that clears the counter |
| clk_code | input | CODE_W | Event code that advances the counter when mode bit 3 is 1 |
| trig_code | input | CODE_W | Event code that captures when mode bit 0 is 1 |
| mode | input | 4 | bit0 event capture, bit1 first-pulse capture, bit2 halt capture, bit3 clock select |
| flag_ack | input | 1 | Clears the capture flag |
| rd_sel | input | SEL_W | Byte index, 0 is the most significant byte |
| count_value | output | CNT_W | Running counter |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag for the interrupt logic |
| rd_byte | output | 8 | Selected byte of the captured value |

## Verification
The assertions take for granted that the strobes and the event code are stable across each clock edge. They also assume the configuration codes do not change in the same cycle as a matching event. The stimulus drives every input just after a rising edge and holds it until the next one. It keeps the sync, clock and trigger codes distinct and fixed during the sweep, so each input pattern maps to one unambiguous expected outcome. A separate reference model in the bench computes that outcome.

// File: rtl/ts_pkg.sv
// Shared definitions for the channel timestamp capture unit.
// Assumes mode vectors are at least four bits wide.
package ts_pkg;
    localparam int MODE_W        = 4;
    localparam int MODE_EV_CAP   = 0;
    localparam int MODE_FIRST    = 1;
    localparam int MODE_HALT     = 2;
    localparam int MODE_CLK_EVT  = 3;
    localparam int BYTE_W        = 8;

    // Which capture sources fired in a cycle.
    typedef struct packed {
        logic on_event;
        logic on_first;
        logic on_halt;
    } cap_src_t;
endpackage

// File: rtl/ts_counter.sv
// Timestamp counter: clears on the sync code and advances on the selected clock.
// The clear wins over an increment. The count wraps naturally at all-ones.
module ts_counter #(
    parameter int CNT_W  = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rev_tick,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic [CODE_W-1:0] sync_code,
    input  logic [CODE_W-1:0] clk_code,
    input  logic              clk_sel_evt,
    output logic [CNT_W-1:0]  count
);
    logic do_clear;
    logic do_inc;

    // Decode clear and increment requests from the event stream and tick.
    always_comb begin
        do_clear = evt_valid && (evt_code == sync_code);
        do_inc   = clk_sel_evt ? (evt_valid && (evt_code == clk_code)) : rev_tick;
    end

    // Counter register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (do_clear)
            count <= '0;
        else if (do_inc)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/ts_trigger.sv
// Capture trigger decode: gates each capture source with its mode enable.
// Purely combinational; several sources may fire together and merge to one.
module ts_trigger #(
    parameter int CODE_W = 8
) (
    input  logic                  evt_valid,
    input  logic [CODE_W-1:0]     evt_code,
    input  logic [CODE_W-1:0]     trig_code,
    input  logic                  first_pulse,
    input  logic                  halt_pulse,
    input  logic [ts_pkg::MODE_W-1:0] mode,
    output ts_pkg::cap_src_t      hits,
    output logic                  fire
);
    import ts_pkg::*;

    // Qualify each source and merge them into one capture request.
    always_comb begin
        hits.on_event = mode[MODE_EV_CAP] && evt_valid && (evt_code == trig_code);
        hits.on_first = mode[MODE_FIRST] && first_pulse;
        hits.on_halt  = mode[MODE_HALT] && halt_pulse;
        fire          = |hits;
    end
endmodule

// File: rtl/ts_capture.sv
// Capture register, sticky flag and byte read-out.
// Assumes CNT_W is a multiple of eight; byte index 0 is the top byte.
module ts_capture #(
    parameter int CNT_W = 32,
    parameter int NB    = CNT_W / ts_pkg::BYTE_W,
    parameter int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fire,
    input  logic                      flag_ack,
    input  logic [CNT_W-1:0]          count,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [CNT_W-1:0]          cap_value,
    output logic                      cap_flag,
    output logic [ts_pkg::BYTE_W-1:0] rd_byte
);
    import ts_pkg::*;

    logic [BYTE_W-1:0] byte_arr [NB];

    // Load the captured value from the pre-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_value <= '0;
        else if (fire)
            cap_value <= count;
    end

    // Sticky flag: a capture sets it and wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_flag <= 1'b0;
        else if (fire)
            cap_flag <= 1'b1;
        else if (flag_ack)
            cap_flag <= 1'b0;
    end

    // Slice the captured value into bytes, most significant first.
    for (genvar b = 0; b < NB; b++) begin : g_bytes
        assign byte_arr[b] = cap_value[CNT_W-1-b*BYTE_W -: BYTE_W];
    end

    // Select the requested byte; out-of-range indices read zero.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NB; i++)
            if (rd_sel == SEL_W'(i))
                rd_byte = byte_arr[i];
    end
endmodule

// File: rtl/ts_capture_unit.sv
// Top of the channel timestamp capture unit: counter, trigger decode and
// capture register. Assumes all inputs are synchronous to clk.
module ts_capture_unit #(
    parameter int CNT_W  = 32,
    parameter int CODE_W = 8,
    localparam int NB    = CNT_W / ts_pkg::BYTE_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rev_tick,
    input  logic                      evt_valid,
    input  logic [CODE_W-1:0]         evt_code,
    input  logic                      first_pulse,
    input  logic                      halt_pulse,
    input  logic [CODE_W-1:0]         sync_code,
    input  logic [CODE_W-1:0]         clk_code,
    input  logic [CODE_W-1:0]         trig_code,
    input  logic [3:0]                mode,
    input  logic                      flag_ack,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [CNT_W-1:0]          count_value,
    output logic [CNT_W-1:0]          cap_value,
    output logic                      cap_flag,
    output logic [7:0]                rd_byte
);
    import ts_pkg::*;

    cap_src_t hits;
    logic     fire;

    ts_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rev_tick    (rev_tick),
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .sync_code   (sync_code),
        .clk_code    (clk_code),
        .clk_sel_evt (mode[MODE_CLK_EVT]),
        .count       (count_value)
    );

    ts_trigger #(.CODE_W(CODE_W)) u_trigger (
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .trig_code   (trig_code),
        .first_pulse (first_pulse),
        .halt_pulse  (halt_pulse),
        .mode        (mode),
        .hits        (hits),
        .fire        (fire)
    );

    ts_capture #(.CNT_W(CNT_W), .NB(NB), .SEL_W(SEL_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .flag_ack  (flag_ack),
        .count     (count_value),
        .rd_sel    (rd_sel),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .rd_byte   (rd_byte)
    );
endmodule

// File: rtl/ts_capture_unit_chk.sv
// Property checker for the timestamp capture unit, bound to its top.
// Observes ports only and recomputes trigger conditions from the inputs.
module ts_capture_unit_chk #(
    parameter int CNT_W  = 32,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rev_tick,
    input logic              evt_valid,
    input logic [CODE_W-1:0] evt_code,
    input logic              first_pulse,
    input logic              halt_pulse,
    input logic [CODE_W-1:0] sync_code,
    input logic [CODE_W-1:0] trig_code,
    input logic [3:0]        mode,
    input logic              flag_ack,
    input logic [CNT_W-1:0]  count_value,
    input logic [CNT_W-1:0]  cap_value,
    input logic              cap_flag
);
    logic is_sync;
    logic any_cap;

    // Reconstruct the sync and capture conditions from the ports.
    always_comb begin
        is_sync = evt_valid && (evt_code == sync_code);
        any_cap = (mode[0] && evt_valid && (evt_code == trig_code))
               || (mode[1] && first_pulse) || (mode[2] && halt_pulse);
    end

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_sync |=> (count_value == '0)); // R2

    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sync |=> ((count_value == $past(count_value))
                   || (count_value == CNT_W'($past(count_value) + CNT_W'(1))))); // R3

    AST_CAPTURE_PRE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        any_cap |=> (cap_value == $past(count_value))); // R6

    AST_NO_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cap |=> $stable(cap_value)); // R9

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        any_cap |=> cap_flag); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_ack) |=> cap_flag); // R11
endmodule

bind ts_capture_unit ts_capture_unit_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rev_tick    (rev_tick),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code),
    .first_pulse (first_pulse),
    .halt_pulse  (halt_pulse),
    .sync_code   (sync_code),
    .trig_code   (trig_code),
    .mode        (mode),
    .flag_ack    (flag_ack),
    .count_value (count_value),
    .cap_value   (cap_value),
    .cap_flag    (cap_flag)
);

// File: tb/test_ts_capture_unit.sv
// Bench for the timestamp capture unit at a 16-bit counter width.
// Sweeps every mode against every input pattern with an arithmetic model.
module test_ts_capture_unit;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam logic [7:0] SYNC_C = 8'h11;
    localparam logic [7:0] CLK_C  = 8'h22;
    localparam logic [7:0] TRIG_C = 8'h33;
    localparam logic [7:0] OTHR_C = 8'h44;

    logic clk = 1'b0;
    logic rst_n, rev_tick, evt_valid, first_pulse, halt_pulse, flag_ack;
    logic [7:0] evt_code, rd_byte;
    logic [3:0] mode;
    logic [0:0] rd_sel;
    logic [CW-1:0] count_value, cap_value;
    logic cap_flag;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [CW-1:0] e_cnt, e_cap;
    logic e_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_capture_unit #(.CNT_W(CW), .CODE_W(8)) i_ts_capture_unit (
        .clk(clk), .rst_n(rst_n), .rev_tick(rev_tick), .evt_valid(evt_valid),
        .evt_code(evt_code), .first_pulse(first_pulse), .halt_pulse(halt_pulse),
        .sync_code(SYNC_C), .clk_code(CLK_C), .trig_code(TRIG_C), .mode(mode),
        .flag_ack(flag_ack), .rd_sel(rd_sel), .count_value(count_value),
        .cap_value(cap_value), .cap_flag(cap_flag), .rd_byte(rd_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rev_tick = 0; evt_valid = 0; evt_code = OTHR_C;
        first_pulse = 0; halt_pulse = 0; flag_ack = 0;
    endtask

    // Apply one vector, advance one edge, compare against the model.
    task automatic apply(input bit rt, input bit ev, input logic [7:0] code,
                         input bit fp, input bit hp, input bit ack);
        bit sync, inc, c_ev, c_fp, c_hp, cond;
        string creq;
        rev_tick = rt; evt_valid = ev; evt_code = code;
        first_pulse = fp; halt_pulse = hp; flag_ack = ack;
        sync = ev && code == SYNC_C;
        inc  = mode[3] ? (ev && code == CLK_C) : rt;
        c_ev = mode[0] && ev && code == TRIG_C;
        c_fp = mode[1] && fp;
        c_hp = mode[2] && hp;
        cond = c_ev || c_fp || c_hp;
        if ((32'(c_ev) + 32'(c_fp) + 32'(c_hp)) > 1) creq = "R10";
        else if (c_ev) creq = "R6";
        else if (c_fp) creq = "R7";
        else if (c_hp) creq = "R8";
        else creq = "R9";
        if (cond) e_cap = e_cnt;
        e_flag = cond ? 1'b1 : (ack ? 1'b0 : e_flag);
        e_cnt = sync ? '0 : (inc ? e_cnt + 1'b1 : e_cnt);
        @(posedge clk); #1;
        idle_inputs();
        check(sync ? "R2" : (mode[3] ? "R4" : "R3"), 32'(count_value), 32'(e_cnt));
        check(creq, 32'(cap_value), 32'(e_cap));
        check("R11", 32'(cap_flag), 32'(e_flag));
    endtask

    task automatic do_reset();
        rst_n = 0; idle_inputs();
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1;
        e_cnt = '0; e_cap = '0; e_flag = 0;
        check("R1", 32'(count_value), 0);
        check("R1", 32'(cap_value), 0);
        check("R1", 32'(cap_flag), 0);
    endtask

    initial begin
        logic [7:0] codes [4];
        codes[0] = SYNC_C; codes[1] = CLK_C; codes[2] = TRIG_C; codes[3] = OTHR_C;
        mode = 4'h0; rd_sel = 0;
        @(negedge clk);
        do_reset();
        // Advance the counter so captures see distinct non-zero values.
        for (int k = 0; k < 5; k++) apply(1, 0, OTHR_C, 0, 0, 0);
        // Sweep every mode against every input pattern (R2..R4, R6..R11).
        for (int m = 0; m < 16; m++) begin
            mode = 4'(m);
            for (int p = 0; p < 128; p++) begin
                apply(p[0], p[1], codes[p[3:2]], p[4], p[5], p[6]);
                // Keep count moving between patterns so captured values differ.
                apply(!mode[3], mode[3], CLK_C, 0, 0, 0);
            end
        end
        // R5: wrap from all-ones to zero on the tick clock.
        mode = 4'h0;
        apply(0, 1, SYNC_C, 0, 0, 0);
        for (int k = 0; k < (1 << CW) - 1; k++) begin
            rev_tick = 1; @(posedge clk); #1;
        end
        rev_tick = 0;
        e_cnt = '1;
        check("R5", 32'(count_value), 32'(e_cnt));
        apply(1, 0, OTHR_C, 0, 0, 0);
        check("R5", 32'(count_value), 0);
        // R12: capture a known value and read both bytes, top byte first.
        mode = 4'b0010;
        apply(0, 1, SYNC_C, 0, 0, 0);
        for (int k = 0; k < 16'h0123; k++) begin
            rev_tick = 1; @(posedge clk); #1;
        end
        rev_tick = 0;
        e_cnt = 16'h0123;
        apply(0, 0, OTHR_C, 1, 0, 0);
        rd_sel = 0; #1;
        check("R12", 32'(rd_byte), 32'h01);
        rd_sel = 1; #1;
        check("R12", 32'(rd_byte), 32'h23);
        // R1: reset in the middle of operation returns everything to zero.
        do_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule